// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the bus-facing register layer of a two-channel asynchronous serial controller. One byte-wide slave port serves both channels. Two address bits pick the target. The lower of the two selects the control port or the data port, and the upper one selects the channel. Their position in the address is set by a shift parameter, so the block can sit on buses with byte, half-word or word register spacing.

Each channel has sixteen write registers and a small set of read registers. Software reaches them indirectly through a per-channel register pointer. A control write while the pointer is zero loads the pointer. The next control access then goes to the register the pointer names, and after that access the pointer drops back to zero. The command field of register 0 can add 8 to the pointer, which opens the upper half of the register file. A field in write register 9 issues soft resets to one channel or to both.

Each channel decodes its configuration registers into a character format (data bits, parity, stop bits) and a baud divisor counted in input clock periods. A data-port write gives a one-cycle transmit strobe with the byte. A receive port with a ready handshake fills the receive holding register, and a data-port read returns and releases it. The line shifter and the interrupt logic are separate blocks.

Top module: `dual_serial_regif`

## Requirements
- R1: Address bit SEL_SHIFT selects the control port (0) or the data port (1). Address bit SEL_SHIFT+1 selects channel 0 (0) or channel 1 (1). All other address bits are ignored, and an access affects only the selected channel.
- R2: A control write while the pointer is 0 loads the pointer with data bits 2:0. If bits 5:3 equal 001, 8 is added. Any other command code leaves the pointer in the range 0 to 7.
- R3: A control write while the pointer is nonzero goes to that register and returns the pointer to 0. Every control read returns the read register at the pointer and returns the pointer to 0.
- R4: A write to register 9 with bits 7:6 equal to 01 resets channel 0, 10 resets channel 1, and 11 resets both. Such a write is not stored and does not change the writing channel's pointer. With bits 7:6 equal to 00, the write has no effect other than clearing the pointer.
- R5: After hard or soft reset, write register 4 = 0x04, register 5 = 0, the time constant = 0, read register 1 = 0x07, and read register 0 = 0x44 (0x7C when the channel's DISABLED_MASK bit is set). The receive enable is off.
- R6: Read registers 12 and 13 return the low and high bytes of the time constant (write registers 12 and 13). Read registers other than 0, 1, 12 and 13 return 0.
- R7: baud_div = 2 × (time constant + 2) × P, where P is 1, 16, 32 or 64 for register 4 bits 7:6 = 00, 01, 10 or 11.
- R8: Data bits come from register 5 bits 6:5: 00→5, 01→7, 10→6, 11→8. Parity enable is register 4 bit 0 and even parity is bit 1. Two stop bits are selected when register 4 bits 3:2 = 11.
- R9: A data write pulses tx_strobe with the byte only when register 5 bit 3 is set. A data write always leaves read register 0 bit 2 and read register 1 bit 0 set.
- R10: rx_ready is high only when register 3 bit 0 is set and read register 0 bit 0 is clear. An accepted byte sets read register 0 bit 0. A data read returns the held byte and clears that bit. A byte offered while rx_ready is low is dropped.
- R11: bus_rdata is valid in the cycle after the read. tx_strobe is high for one cycle after the write. The format outputs follow a register write one cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_valid | input | 2 | Received byte offered, per channel |
| rx_data | input | 16 | Received bytes, channel c at bits 8c+7:8c |
| rx_ready | output | 2 | Receive holding register can accept |
| tx_strobe | output | 2 | Transmit byte strobe, one cycle |
| tx_data | output | 16 | Transmit bytes, per channel |
| fmt_char_bits | output | 8 | Data bits per character, 4 bits per channel |
| fmt_parity_en | output | 2 | Parity enable |
| fmt_parity_even | output | 2 | Even parity select |
| fmt_two_stop | output | 2 | Two stop bits |
| baud_div | output | 2*BAUD_W | Input clocks per bit, BAUD_W bits per channel |

## Verification
The bench sweeps every command code that goes with a pointer load and every register index. A design that reads the pointer's upper bit from the wrong command would return the time constant where 0 is expected. A design that fails to clear the pointer would answer a later status read with another register. It sweeps every combination of clock mode, stop, parity and length over extreme time constants, so an off-by-two divisor or a swapped 6/7-bit code shows up. Reset commands are issued across channels to confirm that the writing channel keeps pointer 9 when only the other channel resets, and the bench watches that a dropped receive byte never replaces a held one.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_N  = 16;
  localparam int PTR_W  = $clog2(REG_N);
  localparam int TC_W   = 2 * BYTE_W;
  localparam int PRE_SH = 6;
  localparam int BAUD_W = TC_W + 1 + PRE_SH + 1;

  localparam logic [PTR_W-1:0] IDX_RST = PTR_W'(9);
  localparam logic [PTR_W-1:0] IDX_TCL = PTR_W'(12);
  localparam logic [PTR_W-1:0] IDX_TCH = PTR_W'(13);

  localparam logic [7:0] RR0_ON  = 8'h44;
  localparam logic [7:0] RR0_OFF = 8'h7C;
  localparam logic [7:0] RR1_RST = 8'h07;

  typedef struct packed {
    logic [3:0] bits;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } char_fmt_t;

  function automatic logic [7:0] wreg_init(input logic [PTR_W-1:0] idx);
    case (idx)
      PTR_W'(4):  return 8'h04;
      PTR_W'(9):  return 8'hC0;
      PTR_W'(11): return 8'h08;
      PTR_W'(14): return 8'h30;
      PTR_W'(15): return 8'hF8;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dsr_addr_dec.sv
module dsr_addr_dec #(
  parameter int ADDR_W    = 4,
  parameter int SEL_SHIFT = 0,
  parameter int NCH       = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              sel_data,
  output logic              sel_ch,
  output logic [NCH-1:0]    ctl_wr,
  output logic [NCH-1:0]    ctl_rd,
  output logic [NCH-1:0]    dat_wr,
  output logic [NCH-1:0]    dat_rd
);
  logic unused_addr;
  assign unused_addr = ^addr;
  assign sel_data = addr[SEL_SHIFT];
  assign sel_ch   = addr[SEL_SHIFT+1];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit       = (sel_ch == 1'(c));
    assign ctl_wr[c] = wr && hit && !sel_data;
    assign ctl_rd[c] = rd && hit && !sel_data;
    assign dat_wr[c] = wr && hit &&  sel_data;
    assign dat_rd[c] = rd && hit &&  sel_data;
  end
endmodule

// File: rtl/dsr_chan.sv
module dsr_chan
  import dsr_pkg::*;
#(
  parameter bit DISABLED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [7:0]        wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic [7:0]        ctl_val,
  output logic [7:0]        rx_hold,
  output logic [1:0]        rst_req,
  output logic              tx_strobe,
  output logic [7:0]        tx_data,
  output logic [7:0]        wr4,
  output logic [7:0]        wr5,
  output logic [TC_W-1:0]   tc
);
  localparam logic [7:0] RR0_INIT = DISABLED ? RR0_OFF : RR0_ON;

  logic [7:0]       wreg [REG_N];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rr0, rr1;
  logic             is_rst_cmd, hi_sel;

  assign is_rst_cmd = ctl_wr && (ptr == IDX_RST) && (wdata[7:6] != 2'b00);
  assign rst_req    = is_rst_cmd ? wdata[7:6] : 2'b00;
  assign hi_sel     = (wdata[5:3] == 3'b001);
  assign rx_ready   = wreg[3][0] && !rr0[0];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < REG_N; i++) wreg[i] <= wreg_init(PTR_W'(i));
      ptr       <= '0;
      rr0       <= RR0_INIT;
      rr1       <= RR1_RST;
      rx_hold   <= '0;
      tx_strobe <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_strobe <= 1'b0;
      if (ctl_wr) begin
        if (ptr == '0) begin
          ptr <= {hi_sel, wdata[2:0]};
        end else if (ptr == IDX_RST) begin
          if (wdata[7:6] == 2'b00) ptr <= '0;
        end else begin
          wreg[ptr] <= wdata;
          ptr       <= '0;
        end
      end else if (ctl_rd) begin
        ptr <= '0;
      end
      if (dat_wr) begin
        rr0[2] <= 1'b1;
        rr1[0] <= 1'b1;
        if (wreg[5][3]) begin
          tx_strobe <= 1'b1;
          tx_data   <= wdata;
        end
      end
      if (dat_rd) rr0[0] <= 1'b0;
      if (rx_valid && rx_ready) begin
        rr0[0]  <= 1'b1;
        rx_hold <= rx_data;
      end
    end
  end

  always_comb begin
    case (ptr)
      PTR_W'(0): ctl_val = rr0;
      PTR_W'(1): ctl_val = rr1;
      IDX_TCL:   ctl_val = wreg[IDX_TCL];
      IDX_TCH:   ctl_val = wreg[IDX_TCH];
      default:   ctl_val = 8'h00;
    endcase
  end

  assign wr4 = wreg[4];
  assign wr5 = wreg[5];
  assign tc  = {wreg[IDX_TCH], wreg[IDX_TCL]};

  // R3
  ptr_idle_after_read_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (ctl_rd && !ctl_wr) |=> (ptr == '0));
  // R4
  rst_cmd_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    is_rst_cmd |=> (ptr == IDX_RST));
  // R10
  rx_hold_kept_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rx_valid && !rx_ready) |=> $stable(rx_hold));
  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (dat_wr && !wr5[3]) |=> !tx_strobe);
  // R11
  tx_only_after_write_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !dat_wr |=> !tx_strobe);
endmodule

// File: rtl/dsr_fmt.sv
module dsr_fmt
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        wr4,
  input  logic [7:0]        wr5,
  input  logic [TC_W-1:0]   tc,
  output char_fmt_t         fmt,
  output logic [BAUD_W-1:0] baud_div
);
  logic [TC_W:0]     tcp;
  logic [BAUD_W-2:0] scaled;
  logic [3:0]        bits_n;
  logic              unused_cfg;

  assign unused_cfg = ^{wr4[5:4], wr5[7], wr5[4:0]};
  assign tcp = {1'b0, tc} + (TC_W+1)'(2);

  always_comb begin
    case (wr4[7:6])
      2'b00:   scaled = (BAUD_W-1)'(tcp);
      2'b01:   scaled = (BAUD_W-1)'(tcp) << 4;
      2'b10:   scaled = (BAUD_W-1)'(tcp) << 5;
      default: scaled = (BAUD_W-1)'(tcp) << PRE_SH;
    endcase
    case (wr5[6:5])
      2'b00:   bits_n = 4'd5;
      2'b01:   bits_n = 4'd7;
      2'b10:   bits_n = 4'd6;
      default: bits_n = 4'd8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt      <= '{bits: 4'd5, par_en: 1'b0, par_even: 1'b0, two_stop: 1'b0};
      baud_div <= BAUD_W'(4);
    end else begin
      fmt.bits     <= bits_n;
      fmt.par_en   <= wr4[0];
      fmt.par_even <= wr4[1];
      fmt.two_stop <= (wr4[3:2] == 2'b11);
      baud_div     <= {scaled, 1'b0};
    end
  end

  // R8
  char_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt.bits >= 4'd5) && (fmt.bits <= 4'd8));
  // R7
  baud_floor_chk: assert property (@(posedge clk) disable iff (rst)
    baud_div >= BAUD_W'(4));
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
#(
  parameter int         ADDR_W        = 4,
  parameter int         SEL_SHIFT     = 0,
  parameter logic [1:0] DISABLED_MASK = 2'b00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [1:0]          rx_valid,
  input  logic [15:0]         rx_data,
  output logic [1:0]          rx_ready,
  output logic [1:0]          tx_strobe,
  output logic [15:0]         tx_data,
  output logic [7:0]          fmt_char_bits,
  output logic [1:0]          fmt_parity_en,
  output logic [1:0]          fmt_parity_even,
  output logic [1:0]          fmt_two_stop,
  output logic [2*BAUD_W-1:0] baud_div
);
  localparam int NCH = 2;

  logic           sel_data, sel_ch;
  logic [NCH-1:0] ctl_wr, ctl_rd, dat_wr, dat_rd, soft_rst;
  logic [1:0]     rst_req [NCH];
  logic [7:0]     ctl_val [NCH];
  logic [7:0]     rx_hold [NCH];

  dsr_addr_dec #(.ADDR_W(ADDR_W), .SEL_SHIFT(SEL_SHIFT), .NCH(NCH)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .sel_data(sel_data), .sel_ch(sel_ch),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]      wr4, wr5;
    logic [TC_W-1:0] tc;
    char_fmt_t       fmt;

    assign soft_rst[c] = rst_req[0][c] | rst_req[1][c];

    dsr_chan #(.DISABLED(DISABLED_MASK[c])) u_chan (
      .clk(clk), .rst(rst), .soft_rst(soft_rst[c]),
      .ctl_wr(ctl_wr[c]), .ctl_rd(ctl_rd[c]), .dat_wr(dat_wr[c]), .dat_rd(dat_rd[c]),
      .wdata(bus_wdata),
      .rx_valid(rx_valid[c]), .rx_data(rx_data[c*8 +: 8]), .rx_ready(rx_ready[c]),
      .ctl_val(ctl_val[c]), .rx_hold(rx_hold[c]), .rst_req(rst_req[c]),
      .tx_strobe(tx_strobe[c]), .tx_data(tx_data[c*8 +: 8]),
      .wr4(wr4), .wr5(wr5), .tc(tc)
    );

    dsr_fmt u_fmt (
      .clk(clk), .rst(rst || soft_rst[c]), .wr4(wr4), .wr5(wr5), .tc(tc),
      .fmt(fmt), .baud_div(baud_div[c*BAUD_W +: BAUD_W])
    );

    assign fmt_char_bits[c*4 +: 4] = fmt.bits;
    assign fmt_parity_en[c]        = fmt.par_en;
    assign fmt_parity_even[c]      = fmt.par_even;
    assign fmt_two_stop[c]         = fmt.two_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= sel_data ? rx_hold[sel_ch] : ctl_val[sel_ch];
  end

  // R1
  one_channel_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_wr, ctl_rd, dat_wr, dat_rd}) || (bus_wr && bus_rd));
endmodule

// File: tb/tb_dual_serial_regif.sv
module tb_dual_serial_regif;
  localparam int SH = 2;
  localparam int AW = 8;
  localparam int BW = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, rdata_dis;
  logic [1:0] rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0] rx_ready, tx_strobe, par_en, par_even, two_stop;
  logic [15:0] tx_data;
  logic [7:0] char_bits;
  logic [2*BW-1:0] baud_div;
  logic [1:0] rx_ready_d, tx_strobe_d, par_en_d, par_even_d, two_stop_d;
  logic [15:0] tx_data_d;
  logic [7:0] char_bits_d;
  logic [2*BW-1:0] baud_div_d;

  dual_serial_regif #(.ADDR_W(AW), .SEL_SHIFT(SH)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_data(tx_data),
    .fmt_char_bits(char_bits), .fmt_parity_en(par_en), .fmt_parity_even(par_even),
    .fmt_two_stop(two_stop), .baud_div(baud_div));

  dual_serial_regif #(.ADDR_W(AW), .SEL_SHIFT(SH), .DISABLED_MASK(2'b10)) dut_dis (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_dis), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready_d), .tx_strobe(tx_strobe_d), .tx_data(tx_data_d),
    .fmt_char_bits(char_bits_d), .fmt_parity_en(par_en_d), .fmt_parity_even(par_even_d),
    .fmt_two_stop(two_stop_d), .baud_div(baud_div_d));

  int total = 0, bad = 0;
  int tx_cnt [2] = '{0, 0};
  logic [7:0] tx_last [2];
  bit done = 0;

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++)
      if (tx_strobe[c]) begin
        tx_cnt[c]++;
        tx_last[c] = tx_data[c*8 +: 8];
      end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input int ch, input bit dat, input bit wr, input logic [7:0] wd,
                    output logic [7:0] rd, output logic [7:0] rd2);
    @(negedge clk);
    bus_addr  = AW'((ch << (SH + 1)) | (int'(dat) << SH) | 3);
    bus_wr    = wr;
    bus_rd    = !wr;
    bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    rd  = bus_rdata;
    rd2 = rdata_dis;
  endtask

  task automatic cw(input int ch, input logic [7:0] v);
    logic [7:0] a, b;
    op(ch, 1'b0, 1'b1, v, a, b);
  endtask

  task automatic cr(input int ch, output logic [7:0] v);
    logic [7:0] b;
    op(ch, 1'b0, 1'b0, 8'h00, v, b);
  endtask

  task automatic wreg(input int ch, input int r, input logic [7:0] v);
    cw(ch, 8'((r & 7) | (r >= 8 ? 8 : 0)));
    cw(ch, v);
  endtask

  task automatic rreg(input int ch, input int r, output logic [7:0] v);
    if (r != 0) cw(ch, 8'((r & 7) | (r >= 8 ? 8 : 0)));
    cr(ch, v);
  endtask

  task automatic push(input int ch, input logic [7:0] v);
    @(negedge clk);
    rx_valid[ch] = 1'b1;
    rx_data[ch*8 +: 8] = v;
    @(negedge clk);
    rx_valid[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_baud(input int tcv, input int cm);
    int pre;
    pre = (cm == 0) ? 1 : (cm == 1) ? 16 : (cm == 2) ? 32 : 64;
    return 2 * (tcv + 2) * pre;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, v2;
    int tcs [4] = '{0, 1, 'h1234, 'hFFFF};
    int cnt0, cnt1;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R5 reset state
    for (int c = 0; c < 2; c++) begin
      op(c, 1'b0, 1'b0, 8'h00, v, v2);
      chk("R5 rr0", v, 8'h44);
      chk("R5 rr0 disabled variant", v2, (c == 1) ? 8'h7C : 8'h44);
      rreg(c, 1, v); chk("R5 rr1", v, 8'h07);
      chk("R5 bits", char_bits[c*4 +: 4], 5);
      chk("R5 baud", baud_div[c*BW +: BW], 4);
      chk("R5 parity/stop", {par_en[c], par_even[c], two_stop[c]}, 0);
      chk("R5 rx disabled", rx_ready[c], 0);
    end

    // R6 R2 R3 full pointer sweep
    for (int c = 0; c < 2; c++) begin
      wreg(c, 12, 8'(8'h5A + c));
      wreg(c, 13, 8'(8'hC3 - c));
      for (int r = 0; r < 16; r++) begin
        int e;
        rreg(c, r, v);
        e = (r == 0) ? 'h44 : (r == 1) ? 'h07 : (r == 12) ? 'h5A + c : (r == 13) ? 'hC3 - c : 0;
        chk($sformatf("R6 rr%0d ch%0d", r, c), v, e);
        cr(c, v);
        chk("R3 pointer cleared after read", v, 8'h44);
      end
      for (int cmd = 0; cmd < 8; cmd++) begin
        cw(c, 8'((cmd << 3) | 4));
        cr(c, v);
        chk($sformatf("R2 cmd%0d ptr", cmd), v, (cmd == 1) ? 8'(8'h5A + c) : 8'h00);
      end
      wreg(c, 2, 8'h99);
      cr(c, v);
      chk("R3 pointer cleared after write", v, 8'h44);
    end

    // R7 R8 sweep
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 4; t++) begin
        wreg(c, 12, 8'(tcs[t]));
        wreg(c, 13, 8'(tcs[t] >> 8));
        for (int cm = 0; cm < 4; cm++)
          for (int st = 0; st < 4; st++)
            for (int pe = 0; pe < 4; pe++)
              for (int ln = 0; ln < 4; ln++) begin
                wreg(c, 4, 8'((cm << 6) | (st << 2) | pe));
                wreg(c, 5, 8'(ln << 5));
                idle(1);
                chk("R7 baud", baud_div[c*BW +: BW], exp_baud(tcs[t], cm));
                chk("R8 bits", char_bits[c*4 +: 4],
                    (ln == 0) ? 5 : (ln == 1) ? 7 : (ln == 2) ? 6 : 8);
                chk("R8 parity", {par_en[c], par_even[c]}, {pe[0], pe[1]});
                chk("R8 stop", two_stop[c], st == 3);
              end
      end

    // R1 channel isolation and address decode
    wreg(0, 4, 8'h00);
    wreg(1, 4, 8'h40);
    idle(1);
    chk("R1 ch0 baud", baud_div[0 +: BW], exp_baud('hFFFF, 0));
    chk("R1 ch1 baud", baud_div[BW +: BW], exp_baud('hFFFF, 1));

    // R11 format timing
    wreg(0, 4, 8'hC0);
    chk("R11 format not yet updated", baud_div[0 +: BW], exp_baud('hFFFF, 0));
    idle(1);
    chk("R11 format updated", baud_div[0 +: BW], exp_baud('hFFFF, 3));

    // R9 transmit
    wreg(0, 5, 8'h60);
    cnt0 = tx_cnt[0];
    op(0, 1'b1, 1'b1, 8'h5A, v, v2);
    idle(2);
    chk("R9 no strobe when disabled", tx_cnt[0], cnt0);
    cr(0, v); chk("R9 rr0 tx empty", v[2], 1);
    rreg(0, 1, v); chk("R9 rr1 all sent", v[0], 1);
    wreg(0, 5, 8'h68);
    cnt1 = tx_cnt[1];
    op(0, 1'b1, 1'b1, 8'hA5, v, v2);
    chk("R11 strobe visible after write", tx_strobe[0], 1);
    idle(3);
    chk("R11 single strobe", tx_cnt[0], cnt0 + 1);
    chk("R9 tx byte", tx_last[0], 8'hA5);
    chk("R1 other channel quiet", tx_cnt[1], cnt1);

    // R10 receive
    push(0, 8'h11);
    chk("R10 not ready when disabled", rx_ready[0], 0);
    cr(0, v); chk("R10 dropped when disabled", v, 8'h44);
    wreg(0, 3, 8'h01);
    chk("R10 ready", rx_ready[0], 1);
    push(0, 8'h33);
    chk("R10 full not ready", rx_ready[0], 0);
    cr(0, v); chk("R10 rx available", v, 8'h45);
    push(0, 8'h77);
    op(0, 1'b1, 1'b0, 8'h00, v, v2);
    chk("R10 held byte kept", v, 8'h33);
    cr(0, v); chk("R10 cleared by read", v, 8'h44);
    chk("R10 ready again", rx_ready[0], 1);

    // R4 reset commands
    wreg(0, 4, 8'hC1);
    wreg(1, 4, 8'h8E);
    push(0, 8'h21);
    wreg(1, 9, 8'h40);
    idle(1);
    chk("R4 ch0 reset format", baud_div[0 +: BW], 4);
    chk("R4 ch0 reset bits", char_bits[3:0], 5);
    chk("R4 ch0 reset parity", par_en[0], 0);
    chk("R4 ch0 rx off", rx_ready[0], 0);
    cr(0, v); chk("R4 ch0 rr0", v, 8'h44);
    chk("R4 ch1 kept", two_stop[1], 1);
    chk("R4 ch1 kept baud", baud_div[BW +: BW], exp_baud('hFFFF, 2));
    cr(1, v); chk("R4 writer pointer kept at 9", v, 8'h00);
    cr(1, v); chk("R4 pointer cleared after", v, 8'h44);
    wreg(0, 9, 8'h80);
    idle(1);
    chk("R4 ch1 reset", {two_stop[1], par_even[1]}, 0);
    chk("R4 ch1 reset baud", baud_div[BW +: BW], 4);
    cr(0, v); chk("R4 ch0 pointer kept", v, 8'h00);
    wreg(1, 4, 8'h0C);
    wreg(0, 4, 8'h0C);
    wreg(0, 9, 8'hC0);
    idle(1);
    chk("R4 both reset", two_stop, 0);
    cr(0, v); chk("R4 self reset pointer", v, 8'h44);
    wreg(0, 4, 8'h0C);
    wreg(0, 9, 8'h15);
    idle(1);
    chk("R4 no-op keeps config", two_stop[0], 1);
    cr(0, v); chk("R4 no-op clears pointer", v, 8'h44);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule